// File: doc/BRIEF.md
# Integer Load Extract and Extend Unit

This unit sits between the integer register file and the data memory port of a load path. From a base register value and a signed 16-bit displacement it forms the byte address sent to memory. When the memory word returns, it picks the addressed byte or halfword lane and widens it to a full register value, either by sign extension or by zero fill. Full-word loads pass the memory word through unchanged.

A load-upper-immediate form builds its result from the displacement alone and does not depend on memory. Halfword and word accesses that are not naturally aligned raise a fault flag instead of producing a result.

The memory word is expected in the same cycle as the address, so the memory read is combinational. The result, the result-valid flag and the fault flag are registered and appear one clock after an accepted strobe.

Top module: `ld_extend_top`

## Requirements
- R1: `mem_addr` always equals `base_val` plus the 16-bit `disp` sign-extended to 32 bits, modulo 2^32, combinationally.
- R2: Op code 0 (signed byte) returns the addressed byte sign-extended to 32 bits. Lanes are big-endian: byte offset `mem_addr[1:0]`=0 selects `mem_rdata[31:24]` and offset 3 selects `[7:0]`.
- R3: Op code 1 (unsigned byte) returns the addressed byte, lanes as in R2, with bits 31:8 zero.
- R4: Op code 2 (signed halfword) returns the addressed halfword sign-extended to 32 bits. `mem_addr[1]`=0 selects `mem_rdata[31:16]` and `mem_addr[1]`=1 selects `[15:0]`.
- R5: Op code 3 (unsigned halfword) returns the halfword selected as in R4, with bits 31:16 zero.
- R6: Op code 4 (word) returns `mem_rdata` unchanged. Codes 6 and 7 behave exactly like code 4.
- R7: Op code 5 (upper immediate) returns `{disp, 16'h0000}` whatever `mem_rdata` holds, and never faults, whatever the address.
- R8: A halfword op with `mem_addr[0]`=1, or a word op with `mem_addr[1:0]`≠0, sets `ld_fault`=1 and `res_valid`=0 one cycle later and leaves `res_data` unchanged. Byte ops never fault.
- R9: After a cycle with `in_valid`=1 and no fault, `res_valid`=1 and `res_data` holds the result one cycle later. After a cycle with `in_valid`=0, `res_valid` and `ld_fault` are both 0 and `res_data` holds its value.
- R10: A synchronous active-high `rst` clears `res_valid`, `ld_fault` and `res_data` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Load strobe for this cycle |
| op_sel | input | 3 | Load kind (codes in R2 to R7) |
| base_val | input | 32 | Base register value |
| disp | input | 16 | Signed displacement / upper immediate |
| mem_rdata | input | 32 | Memory word read at mem_addr |
| mem_addr | output | 32 | Effective byte address |
| res_data | output | 32 | Registered write-back value |
| res_valid | output | 1 | res_data updated this cycle |
| ld_fault | output | 1 | Misaligned access flagged |

## Verification
A wrong lane index or wrong extension shows up in `res_data` on the cycle right after the strobe, so every transaction is compared at that one cycle. A carry or extension error in the address path shows up on `mem_addr` in the strobe cycle itself, before any clock edge. Alignment state shows as a fault flag on a load that should have succeeded, or as a missing one. It can also show as `res_data` moving on a faulted load, which only the held value at the following check reveals.

// File: rtl/ld_pkg.sv
package ld_pkg;
  typedef enum logic [2:0] {
    OP_BYTE_S  = 3'd0,
    OP_BYTE_U  = 3'd1,
    OP_HALF_S  = 3'd2,
    OP_HALF_U  = 3'd3,
    OP_WORD    = 3'd4,
    OP_UPPER   = 3'd5,
    OP_WORD_X6 = 3'd6,
    OP_WORD_X7 = 3'd7
  } ld_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_NONE = 2'd3
  } ld_size_e;

  function automatic ld_size_e op_size(input ld_op_e op);
    case (op)
      OP_BYTE_S, OP_BYTE_U: op_size = SZ_BYTE;
      OP_HALF_S, OP_HALF_U: op_size = SZ_HALF;
      OP_UPPER:             op_size = SZ_NONE;
      default:              op_size = SZ_WORD;
    endcase
  endfunction
endpackage

// File: rtl/ld_agen.sv
module ld_agen
  import ld_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  logic [XLEN-1:0]  base_val,
  input  logic [IMM_W-1:0] disp,
  input  ld_op_e           op,
  output logic [XLEN-1:0]  addr,
  output logic             misalign
);
  localparam int NBYTE = XLEN / 8;
  localparam int OFS_W = $clog2(NBYTE);

  logic [XLEN-1:0] disp_ext;
  ld_size_e        sz;

  assign disp_ext = {{(XLEN-IMM_W){disp[IMM_W-1]}}, disp};
  assign addr     = base_val + disp_ext;
  assign sz       = op_size(op);

  always_comb begin
    case (sz)
      SZ_HALF: misalign = addr[0];
      SZ_WORD: misalign = (addr[OFS_W-1:0] != '0);
      default: misalign = 1'b0;
    endcase
  end

  // R8: an access whose low address bits are clear never faults
  always_comb begin
    if (addr[OFS_W-1:0] == '0)
      assert_aligned_ok_R8: assert (!misalign);
  end
endmodule

// File: rtl/ld_lane_ext.sv
module ld_lane_ext
  import ld_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  logic [XLEN-1:0]          rdata,
  input  logic [$clog2(XLEN/8)-1:0] ofs,
  input  logic [IMM_W-1:0]         disp,
  input  ld_op_e                   op,
  output logic [XLEN-1:0]          value
);
  localparam int NBYTE = XLEN / 8;
  localparam int NHALF = NBYTE / 2;
  localparam int OFS_W = $clog2(NBYTE);

  logic [7:0]  byte_lane [NBYTE];
  logic [15:0] half_lane [NHALF];
  logic [7:0]  b_sel;
  logic [15:0] h_sel;

  for (genvar g = 0; g < NBYTE; g++) begin : g_byte
    assign byte_lane[g] = rdata[XLEN-1-8*g -: 8];
  end
  for (genvar g = 0; g < NHALF; g++) begin : g_half
    assign half_lane[g] = rdata[XLEN-1-16*g -: 16];
  end

  assign b_sel = byte_lane[ofs];
  assign h_sel = half_lane[ofs[OFS_W-1:1]];

  always_comb begin
    case (op)
      OP_BYTE_S: value = {{(XLEN-8){b_sel[7]}}, b_sel};
      OP_BYTE_U: value = {{(XLEN-8){1'b0}}, b_sel};
      OP_HALF_S: value = {{(XLEN-16){h_sel[15]}}, h_sel};
      OP_HALF_U: value = {{(XLEN-16){1'b0}}, h_sel};
      OP_UPPER:  value = {disp, {(XLEN-IMM_W){1'b0}}};
      default:   value = rdata;
    endcase
  end

  // R3 / R5: unsigned forms never carry data above their lane width
  always_comb begin
    if (op == OP_BYTE_U)
      assert_byte_zero_fill_R3: assert (value[XLEN-1:8] == '0);
    if (op == OP_HALF_U)
      assert_half_zero_fill_R5: assert (value[XLEN-1:16] == '0);
  end
endmodule

// File: rtl/ld_extend_top.sv
module ld_extend_top
  import ld_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [2:0]       op_sel,
  input  logic [XLEN-1:0]  base_val,
  input  logic [IMM_W-1:0] disp,
  input  logic [XLEN-1:0]  mem_rdata,
  output logic [XLEN-1:0]  mem_addr,
  output logic [XLEN-1:0]  res_data,
  output logic             res_valid,
  output logic             ld_fault
);
  localparam int OFS_W = $clog2(XLEN / 8);

  ld_op_e          op;
  logic            misalign;
  logic [XLEN-1:0] ext_val;

  assign op = ld_op_e'(op_sel);

  ld_agen #(.XLEN(XLEN), .IMM_W(IMM_W)) u_agen (
    .base_val (base_val),
    .disp     (disp),
    .op       (op),
    .addr     (mem_addr),
    .misalign (misalign)
  );

  ld_lane_ext #(.XLEN(XLEN), .IMM_W(IMM_W)) u_ext (
    .rdata (mem_rdata),
    .ofs   (mem_addr[OFS_W-1:0]),
    .disp  (disp),
    .op    (op),
    .value (ext_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_data  <= '0;
      res_valid <= 1'b0;
      ld_fault  <= 1'b0;
    end else begin
      res_valid <= in_valid && !misalign;
      ld_fault  <= in_valid && misalign;
      if (in_valid && !misalign)
        res_data <= ext_val;
    end
  end

  assert_valid_fault_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(res_valid && ld_fault));

  assert_valid_needs_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    (res_valid || ld_fault) |-> $past(in_valid));

  assert_upper_no_fault_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 3'd5) |=> (res_valid && !ld_fault));

  assert_byte_no_fault_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel[2:1] == 2'b00) |=> !ld_fault);

  assert_fault_holds_data_R8: assert property (@(posedge clk) disable iff (rst)
    ld_fault |-> $stable(res_data));

  assert_idle_holds_data_R9: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> $stable(res_data));
endmodule

// File: tb/ld_extend_top_test.sv
module ld_extend_top_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [2:0]  op_sel;
  logic [31:0] base_val;
  logic [15:0] disp;
  logic [31:0] mem_rdata;
  logic [31:0] mem_addr;
  logic [31:0] res_data;
  logic        res_valid;
  logic        ld_fault;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] held;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ld_extend_top uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
    .base_val(base_val), .disp(disp), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .res_data(res_data), .res_valid(res_valid),
    .ld_fault(ld_fault)
  );

  function automatic logic [31:0] exp_addr(input logic [31:0] b, input logic [15:0] d);
    exp_addr = b + {{16{d[15]}}, d};
  endfunction

  function automatic bit exp_fault(input logic [2:0] op, input logic [31:0] a);
    if (op <= 3'd1)      exp_fault = 1'b0;
    else if (op <= 3'd3) exp_fault = a[0];
    else if (op == 3'd5) exp_fault = 1'b0;
    else                 exp_fault = (a[1:0] != 2'b00);
  endfunction

  function automatic logic [31:0] exp_val(input logic [2:0] op, input logic [31:0] a,
                                          input logic [15:0] d, input logic [31:0] w);
    logic [7:0]  b;
    logic [15:0] h;
    b = w[31 - 8*a[1:0] -: 8];
    h = a[1] ? w[15:0] : w[31:16];
    case (op)
      3'd0: exp_val = {{24{b[7]}}, b};
      3'd1: exp_val = {24'h0, b};
      3'd2: exp_val = {{16{h[15]}}, h};
      3'd3: exp_val = {16'h0, h};
      3'd5: exp_val = {d, 16'h0};
      default: exp_val = w;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'd0: req_of = "R2";
      3'd1: req_of = "R3";
      3'd2: req_of = "R4";
      3'd3: req_of = "R5";
      3'd5: req_of = "R7";
      default: req_of = "R6";
    endcase
  endfunction

  task automatic do_load(input logic [2:0] op, input logic [31:0] b,
                         input logic [15:0] d, input logic [31:0] w);
    logic [31:0] a;
    bit f;
    @(negedge clk);
    in_valid = 1'b1; op_sel = op; base_val = b; disp = d; mem_rdata = w;
    a = exp_addr(b, d);
    f = exp_fault(op, a);
    #1;
    check("R1 addr", mem_addr, a);
    @(negedge clk);
    in_valid = 1'b0;
    if (f) begin
      check("R8 fault", {31'b0, ld_fault}, 32'd1);
      check("R8 valid", {31'b0, res_valid}, 32'd0);
      check("R8 held data", res_data, held);
    end else begin
      check({req_of(op), " fault"}, {31'b0, ld_fault}, 32'd0);
      check("R9 valid", {31'b0, res_valid}, 32'd1);
      held = exp_val(op, a, d, w);
      check({req_of(op), " data"}, res_data, held);
    end
  endtask

  task automatic check_idle();
    @(negedge clk);
    check("R9 idle valid", {31'b0, res_valid}, 32'd0);
    check("R9 idle fault", {31'b0, ld_fault}, 32'd0);
    check("R9 idle data", res_data, held);
  endtask

  initial begin
    automatic int unsigned seed = 32'd20240611;
    void'($urandom(seed));
    rst = 1'b1; in_valid = 1'b0; op_sel = '0; base_val = '0; disp = '0; mem_rdata = '0;
    held = '0;
    repeat (3) @(negedge clk);
    check("R10 valid", {31'b0, res_valid}, 32'd0);
    check("R10 fault", {31'b0, ld_fault}, 32'd0);
    check("R10 data", res_data, 32'd0);
    rst = 1'b0;

    // directed lanes, big-endian
    for (int k = 0; k < 4; k++) do_load(3'd0, 32'h1000 + k, 16'h0, 32'h80_7F_C3_12);
    for (int k = 0; k < 4; k++) do_load(3'd1, 32'h1000 + k, 16'h0, 32'h80_7F_C3_12);
    do_load(3'd2, 32'h2000, 16'h0, 32'h8001_7FFE);
    do_load(3'd2, 32'h2002, 16'h0, 32'h8001_7FFE);
    do_load(3'd2, 32'h2000, 16'h0002, 32'h1234_F00F);
    do_load(3'd3, 32'h2000, 16'h0, 32'h8001_F00F);
    do_load(3'd3, 32'h2000, 16'h0002, 32'h8001_F00F);
    do_load(3'd4, 32'h3000, 16'hFFFC, 32'hDEAD_BEEF);
    do_load(3'd6, 32'h3000, 16'h0004, 32'hCAFE_0001);
    do_load(3'd7, 32'h3000, 16'h0008, 32'h0BAD_F00D);
    // negative displacement and wraparound
    do_load(3'd4, 32'h0000_0000, 16'hFFFC, 32'h5555_AAAA);
    do_load(3'd1, 32'hFFFF_FFFF, 16'h0001, 32'hA1B2_C3D4);
    // upper immediate, odd address, memory data ignored
    do_load(3'd5, 32'h0000_0003, 16'h8765, 32'hFFFF_FFFF);
    do_load(3'd5, 32'h1234_5671, 16'h0001, 32'h0000_0000);
    // misaligned cases
    do_load(3'd2, 32'h4001, 16'h0, 32'h1111_2222);
    do_load(3'd3, 32'h4003, 16'h0, 32'h1111_2222);
    do_load(3'd4, 32'h4002, 16'h0, 32'h3333_4444);
    do_load(3'd4, 32'h4000, 16'h0001, 32'h3333_4444);
    do_load(3'd7, 32'h4003, 16'h0, 32'h3333_4444);
    check_idle();

    for (int i = 0; i < 400; i++) begin
      do_load(3'($urandom_range(0, 7)), $urandom(), 16'($urandom()), $urandom());
      if ($urandom_range(0, 7) == 0) check_idle();
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule